// File: doc/BRIEF.md
# Double-Buffered SPI Master

This block is a byte-wide serial peripheral master with a small synchronous register port. Software picks the clock idle level, the sampling phase, the bit order and a bit rate, connects the pins, enables the block and then writes bytes. A written byte waits in a transmit holding stage until the shifter is free. The shifter then moves it out on MOSI while it shifts the MISO line into a receive shifter. Because the holding stage refills while a byte is on the wire, a stream of bytes runs with no idle clock time between them.

Each finished byte is pushed into a two-entry receive queue and raises a ready event. The event drives the interrupt line when the ready interrupt is unmasked. Reading the receive register pops the oldest byte. If a byte completes while the queue is full, it replaces the newest entry and a sticky overrun flag is raised. The serial clock is divided down from the system clock. The divider is chosen from one of seven one-hot rate codes, and any other code gives the slowest rate.

Top module: `spi_dbuf_master`

## Requirements
- R1: After reset the enable field reads 0, all three pin selects read 0xFFFFFFFF with `sck_oe` and `mosi_oe` low, the ready interrupt is masked, the event register (address 7) reads 0, `irq_o` is low and `sck_o` is low.
- R2: Only the value 1 in the low four bits of address 0 runs the block. With any other value no transfer starts, a queued byte stays queued and `sck_o` stays at the CPOL level.
- R3: Address 1 bit 2 (CPOL) sets the idle level of `sck_o`. With bit 1 (CPHA) at 0, data is sampled on the leading edge and changed on the trailing edge; with CPHA at 1, data is changed on the leading edge and sampled on the trailing edge. Each byte takes 16 SCK edges.
- R4: Address 1 bit 0 selects the bit order: 0 sends and receives the most significant bit first, 1 the least significant bit first.
- R5: Address 2 holds a rate code. The code with only bit 25+i set (i = 0..6) gives a half SCK period of SYS_CLK_HZ/(2·125000·2^i) system clocks. Any other code gives the i = 0 period.
- R6: A write to address 3 fills the transmit holding stage if it is empty; a write while it is full is dropped. Event register bit 2 reads 1 while the holding stage is full.
- R7: When the holding stage is full at the end of a byte, the next byte starts on the same clock. Every SCK edge of a burst, including the edges across byte boundaries, is exactly one half period after the previous edge.
- R8: Reading address 4 returns the oldest received byte and removes it. An empty queue reads 0. Event register bits 4:3 give the number of bytes held (0 to 2).
- R9: A byte completing while two bytes are held replaces the newer one and sets event bit 1. Event bit 1 stays set until a write to address 7 with bit 1 set.
- R10: Event bit 0 is set when each byte completes and is cleared by a write to address 7 with bit 0 set. `irq_o` is high while event bit 0 and the interrupt enable are both set.
- R11: Writing a 1 in bit 2 of address 5 enables the ready interrupt, and writing a 1 in bit 2 of address 6 disables it. A 0 in that bit changes nothing. Reading either address returns the enable in bit 2.
- R12: Addresses 8, 9 and 10 select SCK, MOSI and MISO. Writing 0xFFFFFFFF disconnects the pin and any other value connects it; reads return 0xFFFFFFFF or 0. A disconnected SCK or MOSI drives its `_oe` low, and a disconnected MISO is sampled as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the receive queue at address 4) |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq_o | output | 1 | Ready interrupt |
| sck_o | output | 1 | Serial clock |
| sck_oe | output | 1 | Serial clock pin connected |
| mosi_o | output | 1 | Serial data out |
| mosi_oe | output | 1 | Data-out pin connected |
| miso_i | input | 1 | Serial data in |

## Verification
The assertions assume the register strobes are single-cycle and that at most one of read and write is high on any clock. They also assume the mode and rate registers can change at any time, because the shifter latches both when a byte is loaded. The bench drives each access on the falling clock edge as one strobe of one cycle. It changes the mode and rate only between bursts, while the serial clock is idle. It drives MISO only on the shift edges of its slave model, so the master never samples a value that changes in the same cycle.

// File: rtl/spi_dbuf_pkg.sv
package spi_dbuf_pkg;

   typedef struct packed {
      logic cpol;
      logic cpha;
      logic lsb_first;
   } spi_mode_t;

   typedef enum logic [3:0] {
      A_ENABLE   = 4'd0,
      A_MODE     = 4'd1,
      A_RATE     = 4'd2,
      A_TXDATA   = 4'd3,
      A_RXDATA   = 4'd4,
      A_IE_SET   = 4'd5,
      A_IE_CLR   = 4'd6,
      A_EVENTS   = 4'd7,
      A_SEL_SCK  = 4'd8,
      A_SEL_MOSI = 4'd9,
      A_SEL_MISO = 4'd10
   } spi_reg_e;

   localparam logic [31:0] PIN_DISCONNECT = 32'hFFFF_FFFF;
   localparam int unsigned BASE_BPS       = 125_000;
   localparam int unsigned RATE_STEPS     = 7;
   localparam int unsigned RATE_CODE_LSB  = 25;
   localparam int unsigned IE_BIT         = 2;

endpackage

// File: rtl/spi_rate_sel.sv
module spi_rate_sel #(
   parameter int unsigned SYS_CLK_HZ = 16_000_000,
   parameter int unsigned BASE_BPS   = 125_000,
   parameter int unsigned STEPS      = 7,
   parameter int unsigned CODE_LSB   = 25,
   parameter int unsigned HALF_W     = 7
)(
   input  logic [31:0]       code_i,
   output logic [HALF_W-1:0] half_o
);
   localparam int unsigned BASE_HALF = SYS_CLK_HZ / (2 * BASE_BPS);

   if (CODE_LSB + STEPS > 32) begin : g_bad_code
      $error("rate codes do not fit in 32 bits");
   end
   if ((BASE_HALF >> (STEPS - 1)) == 0) begin : g_bad_clk
      $error("system clock too slow for the fastest rate");
   end
   if ((BASE_HALF % (1 << (STEPS - 1))) != 0) begin : g_bad_div
      $error("system clock does not divide evenly into all rates");
   end

   always_comb begin
      half_o = HALF_W'(BASE_HALF);
      for (int i = 0; i < int'(STEPS); i++) begin
         if (code_i == (32'd1 << (CODE_LSB + i)))
            half_o = HALF_W'(BASE_HALF >> i);
      end
   end
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine import spi_dbuf_pkg::*; #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned HALF_W = 7
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run_i,
   input  logic              start_i,
   input  logic [DATA_W-1:0] tx_i,
   input  spi_mode_t         mode_i,
   input  logic [HALF_W-1:0] half_i,
   input  logic              miso_i,
   output logic              busy_o,
   output logic              last_o,
   output logic [DATA_W-1:0] rx_o,
   output logic              sck_o,
   output logic              mosi_o
);
   localparam int unsigned EDGES  = 2 * DATA_W;
   localparam int unsigned EDGE_W = $clog2(EDGES);
   localparam int unsigned IDX_W  = $clog2(DATA_W);

   if (DATA_W < 2) begin : g_bad_width
      $error("data width must be at least 2");
   end

   logic              busy_q, sck_q;
   logic [EDGE_W-1:0] edge_q;
   logic [HALF_W-1:0] div_q, half_q;
   logic [DATA_W-1:0] tx_q, rx_q, rx_next;
   spi_mode_t         mode_q;
   logic              tick, sample_now;
   logic [IDX_W-1:0]  bit_idx;
   logic [EDGE_W-1:0] edge_m1;

   assign tick       = busy_q && (div_q == half_q - HALF_W'(1));
   assign sample_now = tick && (edge_q[0] == mode_q.cpha);
   assign last_o     = tick && (edge_q == EDGE_W'(EDGES - 1));

   always_comb begin
      if (mode_q.lsb_first) rx_next = {miso_i, rx_q[DATA_W-1:1]};
      else                  rx_next = {rx_q[DATA_W-2:0], miso_i};
   end
   assign rx_o = sample_now ? rx_next : rx_q;

   assign edge_m1 = edge_q - EDGE_W'(1);
   always_comb begin
      if (!mode_q.cpha)      bit_idx = IDX_W'(edge_q >> 1);
      else if (edge_q == '0) bit_idx = '0;
      else                   bit_idx = IDX_W'(edge_m1 >> 1);
   end

   always_comb begin
      if (!busy_q)               mosi_o = 1'b0;
      else if (mode_q.lsb_first) mosi_o = tx_q[bit_idx];
      else                       mosi_o = tx_q[IDX_W'(DATA_W - 1) - bit_idx];
   end

   assign busy_o = busy_q;
   assign sck_o  = busy_q ? sck_q : mode_i.cpol;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         sck_q  <= 1'b0;
         edge_q <= '0;
         div_q  <= '0;
         half_q <= HALF_W'(1);
         tx_q   <= '0;
         rx_q   <= '0;
         mode_q <= '0;
      end else if (!run_i) begin
         busy_q <= 1'b0;
         edge_q <= '0;
         div_q  <= '0;
      end else if (start_i) begin
         busy_q <= 1'b1;
         tx_q   <= tx_i;
         edge_q <= '0;
         div_q  <= '0;
         half_q <= half_i;
         mode_q <= mode_i;
         sck_q  <= mode_i.cpol;
      end else if (busy_q) begin
         if (tick) begin
            div_q  <= '0;
            sck_q  <= ~sck_q;
            edge_q <= edge_q + EDGE_W'(1);
            if (sample_now) rx_q <= rx_next;
            if (last_o) busy_q <= 1'b0;
         end else begin
            div_q <= div_q + HALF_W'(1);
         end
      end
   end
endmodule

// File: rtl/spi_rx_stage.sv
module spi_rx_stage #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned DEPTH  = 2,
   parameter int unsigned CNT_W  = 2
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic              pop_i,
   output logic [DATA_W-1:0] data_o,
   output logic [CNT_W-1:0]  count_o,
   output logic              overrun_o
);
   if (DEPTH < 1) begin : g_bad_depth
      $error("receive depth must be at least 1");
   end

   logic [DATA_W-1:0] slot_q [DEPTH];
   logic [CNT_W-1:0]  cnt_q;
   logic              do_pop, full;

   assign full      = (cnt_q == CNT_W'(DEPTH));
   assign do_pop    = pop_i && (cnt_q != '0);
   assign overrun_o = push_i && !do_pop && full;
   assign data_o    = (cnt_q != '0) ? slot_q[0] : '0;
   assign count_o   = cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         for (int i = 0; i < int'(DEPTH); i++) slot_q[i] <= '0;
      end else begin
         if (do_pop)
            for (int i = 0; i < int'(DEPTH) - 1; i++) slot_q[i] <= slot_q[i+1];
         if (push_i) begin
            if (do_pop)     slot_q[int'(cnt_q) - 1] <= data_i;
            else if (!full) slot_q[int'(cnt_q)]     <= data_i;
            else            slot_q[DEPTH-1]         <= data_i;
         end
         if (do_pop && !push_i)      cnt_q <= cnt_q - CNT_W'(1);
         else if (push_i && !do_pop && !full) cnt_q <= cnt_q + CNT_W'(1);
      end
   end
endmodule

// File: rtl/spi_dbuf_master.sv
module spi_dbuf_master import spi_dbuf_pkg::*; #(
   parameter int unsigned SYS_CLK_HZ = 16_000_000,
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned RX_DEPTH   = 2
)(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_wr,
   input  logic        reg_rd,
   input  logic [3:0]  reg_addr,
   input  logic [31:0] reg_wdata,
   output logic [31:0] reg_rdata,
   output logic        irq_o,
   output logic        sck_o,
   output logic        sck_oe,
   output logic        mosi_o,
   output logic        mosi_oe,
   input  logic        miso_i
);
   localparam int unsigned BASE_HALF = SYS_CLK_HZ / (2 * BASE_BPS);
   localparam int unsigned HALF_W    = $clog2(BASE_HALF + 1);
   localparam int unsigned CNT_W     = $clog2(RX_DEPTH + 1);

   if (DATA_W > 24) begin : g_bad_data
      $error("data width too large for the register port");
   end
   if (CNT_W > 27) begin : g_bad_cnt
      $error("receive depth too large for the event register");
   end

   logic [3:0]        en_q;
   spi_mode_t         mode_q;
   logic [31:0]       rate_q;
   logic              hold_full, ie_q, ev_ready, ev_ovr;
   logic [DATA_W-1:0] hold_data;
   logic              sel_sck, sel_mosi, sel_miso;
   logic              enabled, start, tx_wr, ovr_clr_wr;
   logic              eng_busy, eng_last;
   logic [DATA_W-1:0] eng_rx, rxq_data;
   logic [HALF_W-1:0] half;
   logic [CNT_W-1:0]  rx_cnt;
   logic              rx_ovr, rx_pop;

   assign enabled    = (en_q == 4'd1);
   assign start      = enabled && hold_full && (!eng_busy || eng_last);
   assign tx_wr      = reg_wr && (reg_addr == A_TXDATA);
   assign ovr_clr_wr = reg_wr && (reg_addr == A_EVENTS) && reg_wdata[1];
   assign rx_pop     = reg_rd && (reg_addr == A_RXDATA);

   spi_rate_sel #(
      .SYS_CLK_HZ(SYS_CLK_HZ), .BASE_BPS(BASE_BPS), .STEPS(RATE_STEPS),
      .CODE_LSB(RATE_CODE_LSB), .HALF_W(HALF_W)
   ) u_rate (
      .code_i(rate_q), .half_o(half)
   );

   spi_shift_engine #(.DATA_W(DATA_W), .HALF_W(HALF_W)) u_eng (
      .clk(clk), .rst_n(rst_n), .run_i(enabled), .start_i(start),
      .tx_i(hold_data), .mode_i(mode_q), .half_i(half),
      .miso_i(miso_i & sel_miso), .busy_o(eng_busy), .last_o(eng_last),
      .rx_o(eng_rx), .sck_o(sck_o), .mosi_o(mosi_o)
   );

   spi_rx_stage #(.DATA_W(DATA_W), .DEPTH(RX_DEPTH), .CNT_W(CNT_W)) u_rxq (
      .clk(clk), .rst_n(rst_n), .push_i(eng_last), .data_i(eng_rx),
      .pop_i(rx_pop), .data_o(rxq_data), .count_o(rx_cnt), .overrun_o(rx_ovr)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q      <= '0;
         mode_q    <= '0;
         rate_q    <= 32'd1 << RATE_CODE_LSB;
         hold_full <= 1'b0;
         hold_data <= '0;
         ie_q      <= 1'b0;
         ev_ready  <= 1'b0;
         ev_ovr    <= 1'b0;
         sel_sck   <= 1'b0;
         sel_mosi  <= 1'b0;
         sel_miso  <= 1'b0;
      end else begin
         if (start) hold_full <= 1'b0;
         if (tx_wr && !hold_full) begin
            hold_full <= 1'b1;
            hold_data <= reg_wdata[DATA_W-1:0];
         end
         if (eng_last) ev_ready <= 1'b1;
         else if (reg_wr && reg_addr == A_EVENTS && reg_wdata[0]) ev_ready <= 1'b0;
         if (rx_ovr) ev_ovr <= 1'b1;
         else if (ovr_clr_wr) ev_ovr <= 1'b0;
         if (reg_wr) begin
            case (reg_addr)
               A_ENABLE:   en_q     <= reg_wdata[3:0];
               A_MODE:     mode_q   <= spi_mode_t'(reg_wdata[2:0]);
               A_RATE:     rate_q   <= reg_wdata;
               A_IE_SET:   if (reg_wdata[IE_BIT]) ie_q <= 1'b1;
               A_IE_CLR:   if (reg_wdata[IE_BIT]) ie_q <= 1'b0;
               A_SEL_SCK:  sel_sck  <= (reg_wdata != PIN_DISCONNECT);
               A_SEL_MOSI: sel_mosi <= (reg_wdata != PIN_DISCONNECT);
               A_SEL_MISO: sel_miso <= (reg_wdata != PIN_DISCONNECT);
               default: ;
            endcase
         end
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         A_ENABLE:   reg_rdata[3:0] = en_q;
         A_MODE:     reg_rdata[2:0] = mode_q;
         A_RATE:     reg_rdata = rate_q;
         A_RXDATA:   reg_rdata[DATA_W-1:0] = rxq_data;
         A_IE_SET,
         A_IE_CLR:   reg_rdata[IE_BIT] = ie_q;
         A_EVENTS: begin
            reg_rdata[0] = ev_ready;
            reg_rdata[1] = ev_ovr;
            reg_rdata[2] = hold_full;
            reg_rdata[3 +: CNT_W] = rx_cnt;
         end
         A_SEL_SCK:  reg_rdata = sel_sck  ? '0 : PIN_DISCONNECT;
         A_SEL_MOSI: reg_rdata = sel_mosi ? '0 : PIN_DISCONNECT;
         A_SEL_MISO: reg_rdata = sel_miso ? '0 : PIN_DISCONNECT;
         default: ;
      endcase
   end

   assign irq_o   = ev_ready & ie_q;
   assign sck_oe  = sel_sck;
   assign mosi_oe = sel_mosi;
endmodule

// File: rtl/spi_dbuf_checker.sv
module spi_dbuf_checker #(
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned RX_DEPTH = 2,
   parameter int unsigned CNT_W    = 2
)(
   input logic              clk,
   input logic              rst_n,
   input logic              enabled,
   input logic              cpol,
   input logic              sck_o,
   input logic              eng_last,
   input logic              ev_ready,
   input logic              ev_ovr,
   input logic              ovr_clr_wr,
   input logic [CNT_W-1:0]  rx_cnt,
   input logic              tx_wr,
   input logic              hold_full,
   input logic [DATA_W-1:0] hold_data,
   input logic              start
);
   AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (!enabled && $past(!enabled)) |-> (sck_o == cpol)); // R2

   AST_TX_DROP_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_wr && hold_full && !start) |=> (hold_full && $stable(hold_data))); // R6

   AST_RX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      rx_cnt <= CNT_W'(RX_DEPTH)); // R8

   AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(ev_ovr) && !$past(ovr_clr_wr)) |-> ev_ovr); // R9

   AST_READY_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      eng_last |=> ev_ready); // R10
endmodule

bind spi_dbuf_master spi_dbuf_checker #(
   .DATA_W(DATA_W), .RX_DEPTH(RX_DEPTH), .CNT_W(CNT_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .enabled(enabled), .cpol(mode_q.cpol),
   .sck_o(sck_o), .eng_last(eng_last), .ev_ready(ev_ready), .ev_ovr(ev_ovr),
   .ovr_clr_wr(ovr_clr_wr), .rx_cnt(rx_cnt), .tx_wr(tx_wr),
   .hold_full(hold_full), .hold_data(hold_data), .start(start)
);

// File: tb/spi_dbuf_master_bench.sv
module spi_dbuf_master_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq_o, sck_o, sck_oe, mosi_o, mosi_oe;
   logic        miso_i = 1'b0;

   int vec = 0, bad = 0;
   bit finished = 0;

   // slave model state
   bit    s_cpol = 0, s_cpha = 0, s_lsb = 0;
   bit    burst_on = 0, first_seen = 0;
   bit    prev_sck = 0, prev_mosi = 0;
   bit    miso_bits[$];
   bit    mosi_bits[$];
   int    shifts = 0, edges = 0, cyc = 0, last_cyc = 0, exp_half = 1;
   string spacing_req = "R7";

   always #5 clk = ~clk;

   spi_dbuf_master u_spi_dbuf_master (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .irq_o(irq_o), .sck_o(sck_o), .sck_oe(sck_oe), .mosi_o(mosi_o),
      .mosi_oe(mosi_oe), .miso_i(miso_i)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      vec++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // behavioural slave: watches SCK edges, serves MISO, collects MOSI
   always @(negedge clk) begin
      int idx;
      cyc++;
      if (burst_on && sck_oe && sck_o !== prev_sck) begin
         if (first_seen) chk(spacing_req, "SCK edge spacing", 32'(cyc - last_cyc), 32'(exp_half));
         first_seen = 1;
         last_cyc = cyc;
         edges++;
         if ((prev_sck == s_cpol) ^ s_cpha) mosi_bits.push_back(prev_mosi);
         else shifts++;
      end
      prev_sck = sck_o;
      prev_mosi = mosi_o;
      idx = s_cpha ? ((shifts == 0) ? 0 : shifts - 1) : shifts;
      miso_i = (idx < miso_bits.size()) ? miso_bits[idx] : 1'b0;
   end

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_rd = 1'b1; reg_addr = a;
      #1 d = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic rd_chk(input string req, input string what,
                         input logic [3:0] a, input logic [31:0] exp);
      logic [31:0] d;
      rd(a, d);
      chk(req, what, d, exp);
   endtask

   task automatic slave_load(input logic [7:0] r [3], input int n);
      miso_bits.delete();
      mosi_bits.delete();
      shifts = 0; edges = 0; first_seen = 0;
      for (int k = 0; k < n; k++)
         for (int j = 0; j < 8; j++)
            miso_bits.push_back(s_lsb ? r[k][j] : r[k][7-j]);
   endtask

   function automatic logic [7:0] mosi_byte(input int k);
      logic [7:0] b = '0;
      for (int j = 0; j < 8; j++) begin
         if (8*k + j < mosi_bits.size()) begin
            if (s_lsb) b[j] = mosi_bits[8*k+j];
            else       b[7-j] = mosi_bits[8*k+j];
         end
      end
      return b;
   endfunction

   task automatic xfer(input logic [2:0] m, input logic [31:0] code, input int half,
                       input logic [7:0] t [3], input logic [7:0] r [3], input int n,
                       input string req);
      wr(4'd1, {29'd0, m});
      wr(4'd2, code);
      s_cpol = m[2]; s_cpha = m[1]; s_lsb = m[0];
      @(negedge clk);
      slave_load(r, n);
      exp_half = half;
      burst_on = 1;
      for (int k = 0; k < n; k++) begin
         if (k >= 2) wait (edges >= 16*(k-1));
         wr(4'd3, {24'd0, t[k]});
      end
      wait (edges == 16*n);
      repeat (4) @(negedge clk);
      burst_on = 0;
      chk("R3", "edge count", 32'(edges), 32'(16*n));
      for (int k = 0; k < n; k++)
         chk(req, "byte seen on MOSI", {24'd0, mosi_byte(k)}, {24'd0, t[k]});
   endtask

   initial begin
      logic [7:0] t [3];
      logic [7:0] r [3];
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // reset state
      rd_chk("R1", "enable", 4'd0, 32'd0);
      rd_chk("R1", "sck select", 4'd8, 32'hFFFF_FFFF);
      rd_chk("R1", "events", 4'd7, 32'd0);
      rd_chk("R1", "irq enable", 4'd5, 32'd0);
      chk("R1", "sck_oe", {31'd0, sck_oe}, 32'd0);
      chk("R1", "irq_o", {31'd0, irq_o}, 32'd0);
      chk("R1", "sck_o", {31'd0, sck_o}, 32'd0);

      // connect pins, enable, unmask
      wr(4'd8, 32'd5); wr(4'd9, 32'd6); wr(4'd10, 32'd7);
      rd_chk("R12", "mosi select connected", 4'd9, 32'd0);
      chk("R12", "sck_oe connected", {31'd0, sck_oe}, 32'd1);
      wr(4'd0, 32'd1);
      wr(4'd5, 32'd4);
      rd_chk("R11", "enable via clear address", 4'd6, 32'd4);

      // single byte, mode 0, MSB first, fastest rate
      t = '{8'hA5, 8'h00, 8'h00}; r = '{8'h3C, 8'h00, 8'h00};
      xfer(3'b000, 32'h8000_0000, 1, t, r, 1, "R3");
      chk("R10", "irq after byte", {31'd0, irq_o}, 32'd1);
      rd_chk("R10", "events after byte", 4'd7, 32'h09);
      rd_chk("R8", "received byte", 4'd4, 32'h3C);
      rd_chk("R8", "empty read", 4'd4, 32'h00);
      wr(4'd7, 32'd1);
      chk("R10", "irq after clear", {31'd0, irq_o}, 32'd0);

      // every mode and order, two bytes back to back
      for (int m = 0; m < 8; m++) begin
         int i = (m % 3) + 4;
         t = '{8'h5A ^ 8'(m*17), 8'hC3 ^ 8'(m), 8'h00};
         r = '{8'h96 ^ 8'(m*5), 8'h1E + 8'(m), 8'h00};
         xfer(3'(m), 32'd1 << (25 + i), 64 >> i, t, r, 2, m[0] ? "R4" : "R3");
         chk("R3", "idle level", {31'd0, sck_o}, {31'd0, s_cpol});
         rd_chk("R8", "first of pair", 4'd4, {24'd0, r[0]});
         rd_chk("R4", "second of pair", 4'd4, {24'd0, r[1]});
         wr(4'd7, 32'd3);
      end

      // unknown rate code falls back to slowest
      spacing_req = "R5";
      t = '{8'h69, 8'h00, 8'h00}; r = '{8'hF0, 8'h00, 8'h00};
      xfer(3'b010, 32'h0000_1234, 64, t, r, 1, "R5");
      rd_chk("R5", "byte at fallback rate", 4'd4, 32'hF0);
      wr(4'd7, 32'd3);
      spacing_req = "R7";

      // overrun: three bytes, no reads
      t = '{8'h11, 8'h22, 8'h33}; r = '{8'h81, 8'h82, 8'h83};
      xfer(3'b000, 32'h8000_0000, 1, t, r, 3, "R7");
      rd_chk("R9", "events after overrun", 4'd7, 32'h13);
      rd_chk("R9", "oldest kept", 4'd4, 32'h81);
      rd_chk("R9", "newest replaced", 4'd4, 32'h83);
      wr(4'd7, 32'd1);
      rd_chk("R9", "overrun sticky", 4'd7, 32'h02);
      wr(4'd7, 32'd2);
      rd_chk("R9", "overrun cleared", 4'd7, 32'h00);

      // interrupt mask
      wr(4'd6, 32'd4);
      t = '{8'hE7, 8'h00, 8'h00}; r = '{8'h7E, 8'h00, 8'h00};
      xfer(3'b000, 32'h8000_0000, 1, t, r, 1, "R10");
      chk("R11", "masked irq", {31'd0, irq_o}, 32'd0);
      rd_chk("R10", "event still raised", 4'd7, 32'h09);
      wr(4'd5, 32'd0);
      chk("R11", "zero write to set", {31'd0, irq_o}, 32'd0);
      wr(4'd5, 32'd4);
      chk("R11", "unmasked irq", {31'd0, irq_o}, 32'd1);
      wr(4'd6, 32'd0);
      chk("R11", "zero write to clear", {31'd0, irq_o}, 32'd1);
      rd_chk("R8", "masked byte", 4'd4, 32'h7E);
      wr(4'd7, 32'd3);

      // disabled block holds the queued byte
      wr(4'd0, 32'd2);
      wr(4'd1, 32'd4);
      s_cpol = 1; s_cpha = 0; s_lsb = 0;
      @(negedge clk);
      r = '{8'h42, 8'h00, 8'h00};
      slave_load(r, 1);
      exp_half = 1;
      burst_on = 1;
      wr(4'd3, 32'h77);
      for (int k = 0; k < 40; k++) begin
         @(negedge clk);
         chk("R2", "sck idle while disabled", {31'd0, sck_o}, 32'd1);
      end
      chk("R2", "no edges while disabled", 32'(edges), 32'd0);
      rd_chk("R6", "hold full flag", 4'd7, 32'h04);
      wr(4'd3, 32'h99);
      wr(4'd0, 32'd1);
      wait (edges == 16);
      repeat (60) @(negedge clk);
      burst_on = 0;
      chk("R6", "dropped write sent nothing", 32'(edges), 32'd16);
      chk("R2", "queued byte sent", {24'd0, mosi_byte(0)}, 32'h77);
      rd_chk("R2", "reply to queued byte", 4'd4, 32'h42);
      wr(4'd7, 32'd3);

      // disconnected MISO reads as zero, MOSI select off
      wr(4'd10, 32'hFFFF_FFFF);
      t = '{8'h0F, 8'h00, 8'h00}; r = '{8'hFF, 8'h00, 8'h00};
      xfer(3'b000, 32'h8000_0000, 1, t, r, 1, "R12");
      rd_chk("R12", "MISO disconnected", 4'd4, 32'h00);
      wr(4'd9, 32'hFFFF_FFFF);
      chk("R12", "mosi_oe off", {31'd0, mosi_oe}, 32'd0);
      rd_chk("R12", "mosi select readback", 4'd9, 32'hFFFF_FFFF);

      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         vec++;
         bad++;
         $display("FAIL watchdog: actual running expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
         $finish;
      end
   end
endmodule